// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block is the control state machine in the digital core of a sigma-delta converter that carries out offset and gain calibration. Software writes a two-bit mode field. A nonzero value starts one of three calibration runs. The sequencer then counts output-word periods through each step and tells the front end which input to present: the external pins, the shorted differential pair, or the internal reference divided by the gain. At the end of each step it captures the filter result as the offset or gain coefficient.

The mode field returns to zero as soon as the calibration steps are over. This is the earliest sign that the run is complete. The active-low data-ready flag stays deasserted until one further normal conversion has been stored in the data register. In self-calibration a configurable setup overhead comes before that conversion. The modulator and the decimation filter are outside this block. The block sees them only through a modulator-cycle tick, an output-word tick and the filter result bus.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, drdy_n is 1, mode_rd is 00, src_sel is 00 (external pins), and data_out, offset_coef, gain_coef and zs_code are all zero.
- R2: A write of 01 (self), 10 (zero-scale system) or 11 (full-scale system) while mode_rd is 00 appears on mode_rd on the next cycle. A write of 00 has no effect on any output.
- R3: In self-calibration, src_sel is 01 (shorted inputs) for the first 3 word ticks and 10 (reference divided by gain) for the next 3. System steps keep src_sel at 00.
- R4: In self-calibration, mode_rd reads 00 after the 6th word tick. With the default overhead of 2 periods, drdy_n falls on the 9th word tick and data_out then holds the filter value presented on that tick.
- R5: A system calibration step clears mode_rd on its 3rd word tick and lowers drdy_n on its 4th word tick, loading data_out from that tick.
- R6: After an accepted mode write, drdy_n rises on the first modulator tick that follows the write cycle. It then stays high until the final conversion tick.
- R7: offset_coef takes the filter value of the last word tick of the zero-scale step, and gain_coef takes the filter value of the last word tick of the full-scale step.
- R8: A stand-alone zero-scale system step changes only offset_coef, and a stand-alone full-scale system step changes only gain_coef.
- R9: A mode write that arrives while mode_rd is nonzero is ignored: mode_rd, src_sel and the step timing are unaffected.
- R10: At the end of a zero-scale step, zs_code is loaded with the midscale code (only the top bit set) when bipolar is 1, and with zero when bipolar is 0.
- R11: Outside calibration, every word tick loads data_out from the filter and drives drdy_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| word_tick | input | 1 | One-cycle pulse per output-word period |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode value being written |
| bipolar | input | 1 | Bipolar transfer function selected |
| filt_data | input | DW | Filter result, valid on word_tick |
| mode_rd | output | 2 | Mode field read-back |
| drdy_n | output | 1 | Active-low data ready |
| src_sel | output | 2 | Input source: 00 pins, 01 shorted, 10 reference/gain |
| data_out | output | DW | Data register |
| offset_coef | output | DW | Offset coefficient |
| gain_coef | output | DW | Gain coefficient |
| zs_code | output | DW | Code the zero-scale point maps to |

## Verification
All outputs are registered. The bench drives each stimulus (a write, a modulator tick or a word tick) for exactly one cycle between clock edges. It samples at the falling edge that follows the rising edge which consumed the stimulus, so every result is due one clock after its cause. The multi-period timelines are checked by counting word ticks, not clock cycles. The checks on drdy_n, mode_rd, src_sel and the coefficients land on the 3rd, 4th, 6th and 9th tick as the requirements state. The bench also samples on the tick just before each of those, so that an off-by-one shows up. The data-ready rise is checked both before and after the first modulator tick, which covers the allowed delay window.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ZERO = 3'd1,
    PH_FULL = 3'd2,
    PH_OVH  = 3'd3,
    PH_CONV = 3'd4
  } phase_e;

  localparam logic [1:0] MODE_NORM = 2'b00;
  localparam logic [1:0] MODE_SELF = 2'b01;
  localparam logic [1:0] MODE_SYZS = 2'b10;
  localparam logic [1:0] MODE_SYFS = 2'b11;

  localparam logic [1:0] SRC_PINS   = 2'b00;
  localparam logic [1:0] SRC_SHORT  = 2'b01;
  localparam logic [1:0] SRC_REFDIV = 2'b10;

  function automatic logic [1:0] src_for(input phase_e ph, input logic self_run);
    if (self_run && ph == PH_ZERO) return SRC_SHORT;
    if (self_run && ph == PH_FULL) return SRC_REFDIV;
    return SRC_PINS;
  endfunction
endpackage

// File: rtl/cal_phase_fsm.sv
module cal_phase_fsm
  import cal_pkg::*;
#(
  parameter int ZS_LEN   = 3,
  parameter int FS_LEN   = 3,
  parameter int OVH_LEN  = 2,
  parameter int CONV_LEN = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       word_tick,
  input  logic       start,
  input  logic [1:0] start_mode,
  output logic [1:0] mode_q,
  output logic [1:0] src_q,
  output logic       zs_last,
  output logic       fs_last,
  output logic       conv_last,
  output logic       idle_tick
);
  localparam int MAX_AB  = (ZS_LEN > FS_LEN) ? ZS_LEN : FS_LEN;
  localparam int MAX_CD  = (OVH_LEN > CONV_LEN) ? OVH_LEN : CONV_LEN;
  localparam int MAXLEN  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW      = $clog2(MAXLEN + 1);

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          self_q, self_n;
  logic [1:0]    mode_n;
  logic [CW-1:0] cur_last;
  logic          tick_run, at_last;

  always_comb begin
    unique case (ph_q)
      PH_ZERO: cur_last = CW'(ZS_LEN - 1);
      PH_FULL: cur_last = CW'(FS_LEN - 1);
      PH_OVH:  cur_last = CW'((OVH_LEN > 0 ? OVH_LEN : 1) - 1);
      PH_CONV: cur_last = CW'(CONV_LEN - 1);
      default: cur_last = '0;
    endcase
  end

  assign tick_run  = word_tick && !start;
  assign at_last   = (cnt_q == cur_last);
  assign zs_last   = tick_run && ph_q == PH_ZERO && at_last;
  assign fs_last   = tick_run && ph_q == PH_FULL && at_last;
  assign conv_last = tick_run && ph_q == PH_CONV && at_last;
  assign idle_tick = tick_run && ph_q == PH_IDLE;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    self_n = self_q;
    mode_n = mode_q;
    if (start) begin
      mode_n = start_mode;
      cnt_n  = '0;
      self_n = (start_mode == MODE_SELF);
      ph_n   = (start_mode == MODE_SYFS) ? PH_FULL : PH_ZERO;
    end else if (tick_run && ph_q != PH_IDLE) begin
      if (!at_last) begin
        cnt_n = cnt_q + 1'b1;
      end else begin
        cnt_n = '0;
        unique case (ph_q)
          PH_ZERO: begin
            if (self_q) ph_n = PH_FULL;
            else begin
              ph_n   = PH_CONV;
              mode_n = MODE_NORM;
            end
          end
          PH_FULL: begin
            mode_n = MODE_NORM;
            ph_n   = (self_q && OVH_LEN > 0) ? PH_OVH : PH_CONV;
          end
          PH_OVH:  ph_n = PH_CONV;
          default: begin
            ph_n   = PH_IDLE;
            self_n = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      self_q <= 1'b0;
      mode_q <= MODE_NORM;
      src_q  <= SRC_PINS;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      self_q <= self_n;
      mode_q <= mode_n;
      src_q  <= src_for(ph_n, self_n);
    end
  end
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zs_cap,
  input  logic          fs_cap,
  input  logic          bipolar,
  input  logic [DW-1:0] filt_data,
  output logic [DW-1:0] offset_coef,
  output logic [DW-1:0] gain_coef,
  output logic [DW-1:0] zs_code
);
  localparam int NCOEF = 2;
  localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};

  logic [NCOEF-1:0] cap;
  logic [DW-1:0]    coef_q [NCOEF];

  assign cap = {fs_cap, zs_cap};

  for (genvar i = 0; i < NCOEF; i++) begin : g_coef
    always_ff @(posedge clk) begin
      if (rst)         coef_q[i] <= '0;
      else if (cap[i]) coef_q[i] <= filt_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         zs_code <= '0;
    else if (zs_cap) zs_code <= bipolar ? MIDSCALE : '0;
  end

  assign offset_coef = coef_q[0];
  assign gain_coef   = coef_q[1];
endmodule

// File: rtl/cal_ready_ctrl.sv
module cal_ready_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mod_tick,
  input  logic          load,
  input  logic [DW-1:0] filt_data,
  output logic          drdy_n,
  output logic [DW-1:0] data_out
);
  logic rise_pend;

  always_ff @(posedge clk) begin
    if (rst)            rise_pend <= 1'b0;
    else if (start)     rise_pend <= 1'b1;
    else if (load)      rise_pend <= 1'b0;
    else if (mod_tick)  rise_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_n   <= 1'b1;
      data_out <= '0;
    end else if (load) begin
      drdy_n   <= 1'b0;
      data_out <= filt_data;
    end else if (rise_pend && mod_tick) begin
      drdy_n   <= 1'b1;
    end
  end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int DW       = 16,
  parameter int ZS_LEN   = 3,
  parameter int FS_LEN   = 3,
  parameter int OVH_LEN  = 2,
  parameter int CONV_LEN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mod_tick,
  input  logic          word_tick,
  input  logic          mode_wr,
  input  logic [1:0]    mode_wdata,
  input  logic          bipolar,
  input  logic [DW-1:0] filt_data,
  output logic [1:0]    mode_rd,
  output logic          drdy_n,
  output logic [1:0]    src_sel,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] offset_coef,
  output logic [DW-1:0] gain_coef,
  output logic [DW-1:0] zs_code
);
  logic start, zs_last, fs_last, conv_last, idle_tick;

  // new mode accepted only once the field reads back as zero
  assign start = mode_wr && (mode_wdata != 2'b00) && (mode_rd == 2'b00);

  cal_phase_fsm #(
    .ZS_LEN(ZS_LEN), .FS_LEN(FS_LEN), .OVH_LEN(OVH_LEN), .CONV_LEN(CONV_LEN)
  ) u_fsm (
    .clk(clk), .rst(rst), .word_tick(word_tick),
    .start(start), .start_mode(mode_wdata),
    .mode_q(mode_rd), .src_q(src_sel),
    .zs_last(zs_last), .fs_last(fs_last),
    .conv_last(conv_last), .idle_tick(idle_tick)
  );

  cal_coef_bank #(.DW(DW)) u_coef (
    .clk(clk), .rst(rst), .zs_cap(zs_last), .fs_cap(fs_last),
    .bipolar(bipolar), .filt_data(filt_data),
    .offset_coef(offset_coef), .gain_coef(gain_coef), .zs_code(zs_code)
  );

  cal_ready_ctrl #(.DW(DW)) u_rdy (
    .clk(clk), .rst(rst), .start(start), .mod_tick(mod_tick),
    .load(conv_last || idle_tick), .filt_data(filt_data),
    .drdy_n(drdy_n), .data_out(data_out)
  );
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mod_tick,
  input logic          word_tick,
  input logic          mode_wr,
  input logic [1:0]    mode_rd,
  input logic          drdy_n,
  input logic [1:0]    src_sel,
  input logic [DW-1:0] offset_coef,
  input logic [DW-1:0] gain_coef
);
  a_r4_drdy_falls_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n) |-> $past(word_tick));

  a_r9_mode_changes_on_event: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_wr) && !$past(word_tick)) |-> $stable(mode_rd));

  a_r3_source_only_in_cal: assert property (@(posedge clk) disable iff (rst)
    (src_sel != 2'b00) |-> (mode_rd == 2'b01));

  a_r6_drdy_high_in_cal: assert property (@(posedge clk) disable iff (rst)
    (mode_rd != 2'b00 && $past(mode_rd != 2'b00) && $past(mod_tick)) |-> drdy_n);

  a_r8_offset_own_mode: assert property (@(posedge clk) disable iff (rst)
    !$stable(offset_coef) |-> ($past(mode_rd) == 2'b01 || $past(mode_rd) == 2'b10));

  a_r8_gain_own_mode: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_coef) |-> ($past(mode_rd) == 2'b01 || $past(mode_rd) == 2'b11));
endmodule

bind cal_sequencer cal_sequencer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mod_tick(mod_tick), .word_tick(word_tick),
  .mode_wr(mode_wr), .mode_rd(mode_rd), .drdy_n(drdy_n), .src_sel(src_sel),
  .offset_coef(offset_coef), .gain_coef(gain_coef)
);

// File: tb/tb_cal_sequencer.sv
`timescale 1ns/1ps
module tb_cal_sequencer;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mod_tick = 1'b0, word_tick = 1'b0, mode_wr = 1'b0, bipolar = 1'b0;
  logic [1:0]    mode_wdata = 2'b00;
  logic [DW-1:0] filt_data = '0;
  logic [1:0]    mode_rd, src_sel;
  logic          drdy_n;
  logic [DW-1:0] data_out, offset_coef, gain_coef, zs_code;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cal_sequencer #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .mod_tick(mod_tick), .word_tick(word_tick),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .bipolar(bipolar),
    .filt_data(filt_data), .mode_rd(mode_rd), .drdy_n(drdy_n),
    .src_sel(src_sel), .data_out(data_out), .offset_coef(offset_coef),
    .gain_coef(gain_coef), .zs_code(zs_code)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wtick(input logic [DW-1:0] v);
    @(negedge clk); filt_data = v; word_tick = 1'b1;
    @(negedge clk); word_tick = 1'b0;
  endtask

  task automatic mtick();
    @(negedge clk); mod_tick = 1'b1;
    @(negedge clk); mod_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] m);
    @(negedge clk); mode_wdata = m; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic t_reset();
    chkv("R1 drdy_n", drdy_n, 1);
    chkv("R1 mode_rd", mode_rd, 0);
    chkv("R1 src_sel", src_sel, 0);
    chkv("R1 data_out", data_out, 0);
    chkv("R1 offset", offset_coef, 0);
    chkv("R1 gain", gain_coef, 0);
    chkv("R1 zs_code", zs_code, 0);
  endtask

  task automatic t_normal();
    wtick(16'h0A11);
    chkv("R11 data", data_out, 16'h0A11);
    chkv("R11 drdy_n", drdy_n, 0);
    wtick(16'h0B22);
    chkv("R11 data2", data_out, 16'h0B22);
    wr(2'b00);
    chkv("R2 zero write mode", mode_rd, 0);
    mtick();
    chkv("R2 zero write drdy", drdy_n, 0);
    chkv("R2 zero write src", src_sel, 0);
  endtask

  task automatic t_self();
    bipolar = 1'b0;
    wr(2'b01);
    chkv("R2 self mode", mode_rd, 2'b01);
    chkv("R6 drdy before mod tick", drdy_n, 0);
    chkv("R3 shorted", src_sel, 2'b01);
    mtick();
    chkv("R6 drdy after mod tick", drdy_n, 1);
    wtick(16'h0001);
    wr(2'b10);
    chkv("R9 ignored mode", mode_rd, 2'b01);
    chkv("R9 ignored src", src_sel, 2'b01);
    wtick(16'h0002);
    chkv("R3 still shorted", src_sel, 2'b01);
    wtick(16'h1234);
    chkv("R7 offset", offset_coef, 16'h1234);
    chkv("R10 unipolar zs", zs_code, 0);
    chkv("R3 refdiv", src_sel, 2'b10);
    wtick(16'h0004);
    wtick(16'h0005);
    chkv("R4 mode before 6th", mode_rd, 2'b01);
    wtick(16'h5678);
    chkv("R7 gain", gain_coef, 16'h5678);
    chkv("R4 mode cleared", mode_rd, 0);
    chkv("R3 pins after", src_sel, 0);
    chkv("R6 drdy held", drdy_n, 1);
    wtick(16'h0007);
    wtick(16'h0008);
    chkv("R6 drdy before 9th", drdy_n, 1);
    chkv("R4 data held", data_out, 16'h0B22);
    wtick(16'h9ABC);
    chkv("R4 drdy falls", drdy_n, 0);
    chkv("R4 data", data_out, 16'h9ABC);
  endtask

  task automatic t_sys_zs();
    bipolar = 1'b1;
    wr(2'b10);
    chkv("R2 sys zs mode", mode_rd, 2'b10);
    chkv("R3 sys zs pins", src_sel, 0);
    mtick();
    chkv("R6 sys drdy", drdy_n, 1);
    wtick(16'h0011);
    wtick(16'h0012);
    chkv("R5 mode before 3rd", mode_rd, 2'b10);
    wtick(16'h2222);
    chkv("R5 mode cleared", mode_rd, 0);
    chkv("R7 sys offset", offset_coef, 16'h2222);
    chkv("R8 gain untouched", gain_coef, 16'h5678);
    chkv("R10 bipolar zs", zs_code, 16'h8000);
    chkv("R5 drdy before 4th", drdy_n, 1);
    wtick(16'h3333);
    chkv("R5 drdy falls", drdy_n, 0);
    chkv("R5 data", data_out, 16'h3333);
  endtask

  task automatic t_sys_fs();
    wr(2'b11);
    chkv("R2 sys fs mode", mode_rd, 2'b11);
    chkv("R3 sys fs pins", src_sel, 0);
    mtick();
    wtick(16'h0021);
    wtick(16'h0022);
    wtick(16'h4444);
    chkv("R7 sys gain", gain_coef, 16'h4444);
    chkv("R8 offset untouched", offset_coef, 16'h2222);
    chkv("R8 zs_code untouched", zs_code, 16'h8000);
    chkv("R5 fs mode cleared", mode_rd, 0);
    wtick(16'h5555);
    chkv("R5 fs drdy", drdy_n, 0);
    chkv("R5 fs data", data_out, 16'h5555);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_self();
    t_sys_zs();
    t_sys_fs();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule